// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block lets logic running on a single clock read and write an external static RAM that has no clock of its own. The RAM has a word-wide data bus split into two byte lanes, each gated by its own active-low byte enable. The RAM is selected with an active-low chip enable and steered with active-low write enable and output enable strobes. The controller takes one request at a time from the user side: a word address, write data, a per-lane mask and a read/write flag. It runs the matching strobe sequence on the memory pins and signals completion with a one-cycle ready pulse. A read returns its data on that same pulse.

Each timing limit of the memory is given in nanoseconds as a parameter. The controller turns each limit into a whole number of clock cycles, rounding up, with at least one cycle per phase. The RAM stops driving its outputs only some time after output enable rises, so a write first holds output enable high for a turnaround phase. Only after that does the controller drive the shared data bus. The write is ended by the rise of write enable. Chip enable and the byte enables stay low for one more cycle, during which the data stays driven as hold time. A request whose mask is all zero completes without any strobe.

Top module: `asram_ctrl`

## Requirements
- R1: While `rst` is high, and afterwards until a request arrives, `mem_ce_n`, `mem_we_n`, `mem_oe_n` and both bits of `mem_be_n` are high, `mem_dq` is not driven and `rdy` is low.
- R2: A read request with a non-zero mask drives `mem_ce_n` and `mem_oe_n` low with `mem_we_n` high for the read count, which is 3 cycles at a 20 ns clock. The next cycle has `rdy` high and all strobes high. `rd_data` then holds the bus value sampled on the last access cycle for lanes whose mask bit is set, and zero for the other lanes.
- R3: A write request with a non-zero mask holds `mem_oe_n` high throughout. It runs 1 turnaround cycle with `mem_ce_n` and the byte enables low, then the write-enable count (3 cycles at 20 ns) with `mem_we_n` low. Then comes 1 hold cycle with `mem_we_n` high and chip and byte enables still low, then one completion cycle with `rdy` high and all strobes high.
- R4: The controller drives `mem_dq` only while `mem_oe_n` is high. It starts driving in the first write-enable-low cycle and stops after the hold cycle that follows the rise of `mem_we_n`.
- R5: Mask bit 0 selects the low lane (`mem_dq[7:0]`, `mem_be_n[0]`) and mask bit 1 the high lane (`mem_dq[15:8]`, `mem_be_n[1]`). Only lanes whose mask bit is set have their byte enable low and are driven with their write-data byte. The other lanes stay released, so their stored bytes are left unchanged.
- R6: During a transaction `mem_addr` equals the request address, and neither the address nor the byte enables change while `mem_ce_n` is low.
- R7: `rdy` is high for exactly one cycle per accepted request.
- R8: A request with mask `00` completes in the cycle after acceptance with `rdy` high. No strobe goes low, and for a read `rd_data` is zero.
- R9: A request raised while a transaction is in progress, including its completion cycle, is ignored. It causes no strobe activity and no extra `rdy` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Request strobe, sampled while idle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane mask, bit 0 low byte, bit 1 high byte |
| rdy | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Read data, valid with `rdy` |
| mem_addr | output | 18 | Memory word address |
| mem_dq | inout | 16 | Shared memory data bus |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_be_n | output | 2 | Byte enables, active low, bit 0 low lane |

## Verification
The assertions watch several rules on every cycle. The bus is driven only while output enable is high, and only on enabled lanes. Write enable never falls without chip enable, a byte enable and a high output enable. The address and byte enables hold steady while the chip is selected. Ready never lasts two cycles, and an empty mask yields an immediate quiet completion. The exact phase lengths, the per-lane merging of writes into stored words, the read data returned, and the rejection of requests made while busy can only be shown by the bench scenarios. The bench compares every pin against a per-cycle expected trace and checks the contents of a behavioural memory.

// File: rtl/asram_pkg.sv
package asram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_TURN,
        ST_WPULSE,
        ST_WHOLD,
        ST_DONE
    } asram_state_e;

    // nanoseconds to whole clock cycles, rounded up, never below one
    function automatic int unsigned ns_to_cyc(int unsigned ns, int unsigned period);
        int unsigned c;
        c = (ns + period - 1) / period;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int unsigned max_u(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // a - b, saturating at one cycle
    function automatic int unsigned sub_min1(int unsigned a, int unsigned b);
        return (a > b + 1) ? (a - b) : 1;
    endfunction

endpackage

// File: rtl/asram_timer.sv
module asram_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] len,
    output logic          last
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = len - CW'(1);
        else if (cnt_q != '0)
            cnt_d = cnt_q - CW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign last = (cnt_q == '0);

endmodule

// File: rtl/asram_lane.sv
module asram_lane #(
    parameter int W = 8
) (
    input  logic         en,
    input  logic [W-1:0] bus_in,
    output logic [W-1:0] cap
);
    // a lane that was not requested returns zero
    assign cap = en ? bus_in : '0;
endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
    import asram_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 20,
    parameter int AW            = 18,
    parameter int DW            = 16,
    parameter int T_RC_NS       = 55,
    parameter int T_AA_NS       = 55,
    parameter int T_DOE_NS      = 25,
    parameter int T_HZOE_NS     = 20,
    parameter int T_PWE_NS      = 45,
    parameter int T_BW_NS       = 50,
    parameter int T_SD_NS       = 25,
    parameter int T_WC_NS       = 55
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req,
    input  logic               req_we,
    input  logic [AW-1:0]      req_addr,
    input  logic [DW-1:0]      req_wdata,
    input  logic [DW/8-1:0]    req_mask,
    output logic               rdy,
    output logic [DW-1:0]      rd_data,
    output logic [AW-1:0]      mem_addr,
    inout  wire  [DW-1:0]      mem_dq,
    output logic               mem_ce_n,
    output logic               mem_we_n,
    output logic               mem_oe_n,
    output logic [DW/8-1:0]    mem_be_n
);
    localparam int LANES = DW / 8;
    localparam int unsigned P = CLK_PERIOD_NS;
    localparam int unsigned RD_CYC = max_u(max_u(ns_to_cyc(T_RC_NS, P),
                                                 ns_to_cyc(T_AA_NS, P)),
                                           ns_to_cyc(T_DOE_NS, P));
    localparam int unsigned TURN_CYC = ns_to_cyc(T_HZOE_NS, P);
    // byte enables span turn + pulse + hold; the write cycle spans the same
    localparam int unsigned WE_CYC = max_u(
        max_u(ns_to_cyc(T_PWE_NS, P), ns_to_cyc(T_SD_NS, P)),
        max_u(sub_min1(ns_to_cyc(T_BW_NS, P), TURN_CYC + 1),
              sub_min1(ns_to_cyc(T_WC_NS, P), TURN_CYC + 1)));
    localparam int unsigned MAX_CYC = max_u(max_u(RD_CYC, TURN_CYC), WE_CYC);
    localparam int CW = $clog2(MAX_CYC + 1);

    typedef struct packed {
        asram_state_e     st;
        logic [AW-1:0]    addr;
        logic [DW-1:0]    wdata;
        logic [LANES-1:0] mask;
        logic [DW-1:0]    rdata;
        logic             ce_n;
        logic             we_n;
        logic             oe_n;
        logic [LANES-1:0] be_n;
        logic [LANES-1:0] drv;
        logic             rdy;
    } regs_t;

    regs_t         d, q;
    logic          t_load, t_last;
    logic [CW-1:0] t_len;
    logic [DW-1:0] cap;

    asram_timer #(.CW(CW)) i_timer (
        .clk  (clk),
        .rst  (rst),
        .load (t_load),
        .len  (t_len),
        .last (t_last)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        asram_lane #(.W(8)) i_lane (
            .en     (q.mask[l]),
            .bus_in (mem_dq[l*8 +: 8]),
            .cap    (cap[l*8 +: 8])
        );
        assign mem_dq[l*8 +: 8] = q.drv[l] ? q.wdata[l*8 +: 8] : 8'hzz;
    end

    always_comb begin
        d      = q;
        d.rdy  = 1'b0;
        t_load = 1'b0;
        t_len  = CW'(1);
        unique case (q.st)
            ST_IDLE: begin
                if (req) begin
                    d.addr  = req_addr;
                    d.wdata = req_wdata;
                    d.mask  = req_mask;
                    if (req_mask == '0) begin
                        d.st    = ST_DONE;
                        d.rdy   = 1'b1;
                        d.rdata = '0;
                    end else if (req_we) begin
                        d.st   = ST_TURN;
                        d.ce_n = 1'b0;
                        d.be_n = ~req_mask;
                        t_load = 1'b1;
                        t_len  = CW'(TURN_CYC);
                    end else begin
                        d.st   = ST_READ;
                        d.ce_n = 1'b0;
                        d.oe_n = 1'b0;
                        d.be_n = ~req_mask;
                        t_load = 1'b1;
                        t_len  = CW'(RD_CYC);
                    end
                end
            end
            ST_READ: begin
                if (t_last) begin
                    d.st    = ST_DONE;
                    d.rdata = cap;
                    d.rdy   = 1'b1;
                    d.ce_n  = 1'b1;
                    d.oe_n  = 1'b1;
                    d.be_n  = '1;
                end
            end
            ST_TURN: begin
                if (t_last) begin
                    d.st   = ST_WPULSE;
                    d.we_n = 1'b0;
                    d.drv  = q.mask;
                    t_load = 1'b1;
                    t_len  = CW'(WE_CYC);
                end
            end
            ST_WPULSE: begin
                if (t_last) begin
                    d.st   = ST_WHOLD;
                    d.we_n = 1'b1;
                end
            end
            ST_WHOLD: begin
                d.st   = ST_DONE;
                d.drv  = '0;
                d.ce_n = 1'b1;
                d.be_n = '1;
                d.rdy  = 1'b1;
            end
            ST_DONE: d.st = ST_IDLE;
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q      <= '0;
            q.st   <= ST_IDLE;
            q.ce_n <= 1'b1;
            q.we_n <= 1'b1;
            q.oe_n <= 1'b1;
            q.be_n <= '1;
        end else begin
            q <= d;
        end
    end

    assign rdy      = q.rdy;
    assign rd_data  = q.rdata;
    assign mem_addr = q.addr;
    assign mem_ce_n = q.ce_n;
    assign mem_we_n = q.we_n;
    assign mem_oe_n = q.oe_n;
    assign mem_be_n = q.be_n;

    // R4: bus is only driven while the memory's outputs are disabled
    p_drive_oe_high_r4: assert property (@(posedge clk) disable iff (rst)
        (|q.drv) |-> (mem_oe_n && !mem_ce_n))
        else $error("R4 bus driven with output enable low");

    // R5: a driven lane always has its byte enable low
    p_drive_lane_en_r5: assert property (@(posedge clk) disable iff (rst)
        (|q.drv) |-> ((q.drv & mem_be_n) == '0))
        else $error("R5 driven lane with byte enable high");

    // R3: write enable low only inside a selected, output-disabled access
    p_we_context_r3: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> (!mem_ce_n && mem_oe_n && (mem_be_n != '1)))
        else $error("R3 write strobe outside a valid write");

    // R4: data still driven in the cycle after write enable rises
    p_hold_after_we_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> (|q.drv))
        else $error("R4 data released with write enable rise");

    // R2: output enable low only for a read with write enable high
    p_read_we_high_r2: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> (mem_we_n && !mem_ce_n))
        else $error("R2 output enable low outside a read");

    // R6: address and lane enables steady while selected
    p_addr_stable_r6: assert property (@(posedge clk) disable iff (rst)
        (!mem_ce_n && $past(!mem_ce_n)) |-> ($stable(mem_addr) && $stable(mem_be_n)))
        else $error("R6 address or byte enable changed while selected");

    // R7: ready is a single-cycle pulse
    p_rdy_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        rdy |=> !rdy)
        else $error("R7 ready held longer than one cycle");

    // R8: empty mask completes at once without selecting the memory
    p_empty_mask_r8: assert property (@(posedge clk) disable iff (rst)
        (q.st == ST_IDLE && req && req_mask == '0) |=> (rdy && mem_ce_n && mem_be_n == '1))
        else $error("R8 empty-mask request touched the memory");

endmodule

// File: tb/test_asram_ctrl.sv
module test_asram_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic        req_we = 1'b0;
    logic [17:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_mask = '0;
    logic        rdy;
    logic [15:0] rd_data;
    logic [17:0] mem_addr;
    wire  [15:0] mem_dq;
    logic        mem_ce_n, mem_we_n, mem_oe_n;
    logic [1:0]  mem_be_n;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #10 clk = ~clk;

    asram_ctrl i_asram_ctrl (
        .clk(clk), .rst(rst), .req(req), .req_we(req_we), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_mask(req_mask), .rdy(rdy), .rd_data(rd_data),
        .mem_addr(mem_addr), .mem_dq(mem_dq), .mem_ce_n(mem_ce_n),
        .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_be_n(mem_be_n)
    );

    // behavioural memory on the pins
    logic [15:0] dev [0:63];
    logic [15:0] ref_mem [0:63];
    wire rd_on = !mem_ce_n && !mem_oe_n && mem_we_n;
    assign mem_dq[7:0]  = (rd_on && !mem_be_n[0]) ? dev[mem_addr[5:0]][7:0]  : 8'hzz;
    assign mem_dq[15:8] = (rd_on && !mem_be_n[1]) ? dev[mem_addr[5:0]][15:8] : 8'hzz;

    typedef struct packed {
        logic        ce, we, oe;
        logic [1:0]  be;
        logic [1:0]  drv;
        logic        rdy;
        logic        rd;
        logic [17:0] addr;
        logic [15:0] wd;
        logic [15:0] rdv;
    } exp_t;

    exp_t exp_q[$];

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: got %h expected %h (cycle %0d)", tag, what, act, expv, cyc);
        end
    endtask

    function automatic exp_t mk(logic ce, logic we, logic oe, logic [1:0] be,
                                logic [1:0] drv, logic r, logic rd,
                                logic [17:0] a, logic [15:0] wd, logic [15:0] rdv);
        exp_t e;
        e.ce = ce; e.we = we; e.oe = oe; e.be = be; e.drv = drv; e.rdy = r;
        e.rd = rd; e.addr = a; e.wd = wd; e.rdv = rdv;
        return e;
    endfunction

    // expected per-cycle pin trace of one request (20 ns clock: read 3, turn 1, WE 3, hold 1)
    task automatic push_seq(input bit wr, input logic [17:0] a, input logic [15:0] wd,
                            input logic [1:0] m);
        logic [15:0] cur;
        logic [15:0] rv;
        cur = ref_mem[a[5:0]];
        if (m == 2'b00) begin
            exp_q.push_back(mk(1, 1, 1, 2'b11, 2'b00, 1, !wr, a, wd, 16'h0000));
        end else if (!wr) begin
            rv = {m[1] ? cur[15:8] : 8'h00, m[0] ? cur[7:0] : 8'h00};
            for (int i = 0; i < 3; i++)
                exp_q.push_back(mk(0, 1, 0, ~m, 2'b00, 0, 1, a, wd, 16'h0));
            exp_q.push_back(mk(1, 1, 1, 2'b11, 2'b00, 1, 1, a, wd, rv));
        end else begin
            exp_q.push_back(mk(0, 1, 1, ~m, 2'b00, 0, 0, a, wd, 16'h0));
            for (int i = 0; i < 3; i++)
                exp_q.push_back(mk(0, 0, 1, ~m, m, 0, 0, a, wd, 16'h0));
            exp_q.push_back(mk(0, 1, 1, ~m, m, 0, 0, a, wd, 16'h0));
            exp_q.push_back(mk(1, 1, 1, 2'b11, 2'b00, 1, 0, a, wd, 16'h0));
            if (m[0]) ref_mem[a[5:0]][7:0]  = wd[7:0];
            if (m[1]) ref_mem[a[5:0]][15:8] = wd[15:8];
        end
    endtask

    // per-cycle comparison, sampled on the falling edge
    always @(negedge clk) begin
        exp_t  e;
        string tg;
        if (!rst) begin
            if (exp_q.size() != 0) begin
                e  = exp_q.pop_front();
                tg = (e.ce && e.rdy) ? ((e.rd && e.rdv == 16'h0 && e.addr == e.addr) ? "R7" : "R7") : (e.oe ? "R3" : "R2");
            end else begin
                e  = mk(1, 1, 1, 2'b11, 2'b00, 0, 0, '0, '0, '0);
                tg = "R9";
            end
            check(mem_ce_n === e.ce, tg, "ce_n", {31'b0, mem_ce_n}, {31'b0, e.ce});
            check(mem_we_n === e.we, tg, "we_n", {31'b0, mem_we_n}, {31'b0, e.we});
            check(mem_oe_n === e.oe, tg, "oe_n", {31'b0, mem_oe_n}, {31'b0, e.oe});
            check(mem_be_n === e.be, "R5", "be_n", {30'b0, mem_be_n}, {30'b0, e.be});
            check(rdy === e.rdy, "R7", "rdy", {31'b0, rdy}, {31'b0, e.rdy});
            if (!e.ce)
                check(mem_addr === e.addr, "R6", "addr", {14'b0, mem_addr}, {14'b0, e.addr});
            if (e.rdy && e.rd)
                check(rd_data === e.rdv, "R2", "rd_data", {16'b0, rd_data}, {16'b0, e.rdv});
            for (int l = 0; l < 2; l++) begin
                if (e.drv[l])
                    check(mem_dq[l*8 +: 8] === e.wd[l*8 +: 8], "R4", "driven lane",
                          {24'b0, mem_dq[l*8 +: 8]}, {24'b0, e.wd[l*8 +: 8]});
                else if (e.oe)
                    check(mem_dq[l*8 +: 8] === 8'hzz, "R5", "released lane",
                          {24'b0, mem_dq[l*8 +: 8]}, 32'h0);
            end
            // memory takes data while write strobe and lane enable are low
            if (!mem_ce_n && !mem_we_n) begin
                if (!mem_be_n[0]) dev[mem_addr[5:0]][7:0]  = mem_dq[7:0];
                if (!mem_be_n[1]) dev[mem_addr[5:0]][15:8] = mem_dq[15:8];
            end
        end
    end

    task automatic wait_idle();
        do begin
            @(negedge clk); #1;
        end while (exp_q.size() != 0);
        @(negedge clk); #1;
    endtask

    task automatic do_req(input bit wr, input logic [17:0] a, input logic [15:0] wd,
                          input logic [1:0] m);
        wait_idle();
        req = 1'b1; req_we = wr; req_addr = a; req_wdata = wd; req_mask = m;
        push_seq(wr, a, wd, m);
        @(negedge clk); #1;
        req = 1'b0;
    endtask

    // R9: a second request pulsed while busy must leave no trace
    task automatic stray_req(input int delay);
        for (int i = 0; i < delay; i++) begin
            @(negedge clk); #1;
        end
        req = 1'b1; req_we = 1'b0; req_addr = 18'h00021; req_mask = 2'b11;
        @(negedge clk); #1;
        req = 1'b0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 20000) begin
            fails++; checks++;
            $display("FAIL watchdog: got hung expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 64; i++) begin
            dev[i]     = 16'h3C00 + 16'(i * 16'h0107);
            ref_mem[i] = 16'h3C00 + 16'(i * 16'h0107);
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        check(mem_ce_n === 1'b1 && mem_we_n === 1'b1 && mem_oe_n === 1'b1, "R1",
              "strobes in reset", {29'b0, mem_ce_n, mem_we_n, mem_oe_n}, 32'h7);
        check(mem_be_n === 2'b11, "R1", "be_n in reset", {30'b0, mem_be_n}, 32'h3);
        check(rdy === 1'b0, "R1", "rdy in reset", {31'b0, rdy}, 32'h0);
        check(mem_dq === 16'hzzzz, "R1", "bus in reset", {16'b0, mem_dq}, 32'h0);
        #1 rst = 1'b0;

        do_req(0, 18'h00005, 16'h0, 2'b11);          // R2 read initial content
        do_req(1, 18'h00005, 16'hBEEF, 2'b11);       // R3 full write
        do_req(0, 18'h00005, 16'h0, 2'b11);          // R2 read back
        do_req(1, 18'h00005, 16'h0012, 2'b01);       // R5 low lane only
        do_req(0, 18'h00005, 16'h0, 2'b11);          // R5 high byte kept
        do_req(1, 18'h20009, 16'hA700, 2'b10);       // R5 high lane only
        do_req(0, 18'h20009, 16'h0, 2'b01);          // R2 low lane read, high zero
        do_req(0, 18'h20009, 16'h0, 2'b10);          // R2 high lane read
        do_req(1, 18'h00005, 16'hFFFF, 2'b00);       // R8 empty write
        do_req(0, 18'h00005, 16'h0, 2'b00);          // R8 empty read, data zero
        do_req(0, 18'h00005, 16'h0, 2'b11);          // R8 content unchanged
        do_req(1, 18'h0003F, 16'h5A5A, 2'b11);       // R9 with stray request
        stray_req(2);
        do_req(0, 18'h0003F, 16'h0, 2'b11);
        stray_req(3);                                // R9 stray in completion cycle
        do_req(1, 18'h00000, 16'h1234, 2'b11);       // back to back write/read
        do_req(0, 18'h00000, 16'h0, 2'b11);
        wait_idle();
        repeat (4) @(negedge clk);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule